// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Controller

This block is the bus-facing half of a small byte-addressed non-volatile memory that answers on an I2C bus as a slave. The bus lines reach it asynchronously and are oversampled by the system clock. START and STOP are detected from the synchronised lines. The data line is driven only through an output-enable: when the enable is high, the pad is pulled low, as an open-drain driver does. The storage is an internal register array that stands in for the non-volatile cells.

A transfer begins with a seven-bit device address. Its upper four bits are a fixed type code. Its lower three bits must match three strap inputs. A write transfer carries two address bytes and one data byte. The data byte is committed only when the master sends STOP. The block then models the self-timed programming cycle: for a parameterised number of clocks it answers nothing on the bus. A read transfer streams bytes from the internal pointer, which advances and wraps, until the master declines a byte. A random read is formed as follows: a write transfer that stops after the address bytes sets the pointer, and a repeated START then opens the read.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: The device address byte is the type code 1010 in its four most significant bits, then strap_i[2:0], then the direction bit as bit 0 (1 = read). The block acknowledges the address byte only when the type code and strap bits match. A mismatch leaves SDA released for the rest of the transfer.
- R2: In a write transfer, the block holds sda_oe_o high (SDA low) through the ninth SCL clock of the address byte, both pointer bytes and the data byte. sda_oe_o changes only while SCL is low.
- R3: With ADDR_W address bits, the pointer takes the low ADDR_W-8 bits of the first pointer byte and all 8 bits of the second. The remaining upper bits of the first byte are ignored (default ADDR_W = 11, so 3 bits are taken from the first byte).
- R4: A byte write is stored only on the STOP that follows the acknowledged data byte. After that STOP, the pointer holds the written address plus one. A STOP before the data byte completes, or a repeated START after it, stores nothing and starts no programming cycle.
- R5: From a committing STOP, the block is busy for exactly PROG_CYCLES clocks. While busy, it keeps SDA released and acknowledges nothing, its own address included. After that it answers normally again.
- R6: In a read transfer, the block sends the byte at the pointer, most significant bit first, and releases SDA in the ninth clock. The pointer advances by one after each byte sent. When the master acknowledges, the next byte follows.
- R7: After the master declines a byte, the block keeps SDA released until the next START or STOP. Further clocks therefore read as 0xFF.
- R8: The pointer wraps from address 2^ADDR_W-1 to address 0.
- R9: A repeated START at any point outside the programming cycle clears the bit count and returns the block to device address matching.
- R10: After reset, SDA is released and the pointer is 0. Memory contents are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous reset, active low |
| strap_i | input | 3 | Pin-strapped low bits of the device address |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
Two functions can meet on the single clock in which a STOP ends a write. In that cycle the array write, the pointer advance to address plus one, and entry into the busy window all take place together. The bench provokes this by issuing a read of the current address right after the wait. It judges the result by reading back the byte that was written one address above, beforehand. It also provokes a collision between a repeated START and a write that is still pending. Here the bench expects an immediate acknowledge with no busy window, and a readback of the old byte.

// File: rtl/i2c_ee_pkg.sv
// Shared types for the I2C EEPROM slave.
package i2c_ee_pkg;
    // Fixed device type code in the top nibble of the address byte.
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    // Protocol states of the slave controller.
    typedef enum logic [3:0] {
        ST_IDLE,   // waiting for START
        ST_DEV,    // receiving the device address byte
        ST_AHI,    // receiving the upper pointer byte
        ST_ALO,    // receiving the lower pointer byte
        ST_WDAT,   // receiving the write data byte
        ST_ACK,    // ninth clock owned by the slave, or lead-in to a read byte
        ST_RDAT,   // shifting a read byte out
        ST_RACK,   // ninth clock of a read: sampling the master answer
        ST_HOLD,   // released, waiting for START or STOP
        ST_PROG    // programming cycle: deaf to the bus
    } ee_state_t;
endpackage

// File: rtl/i2c_ee_sync.sv
// Bus line synchroniser and event detector.
// Brings SCL and SDA into the clock domain through SYNC_STAGES flops and
// flags SCL edges and START/STOP conditions, one clock each.
// Assumes the bus is slower than the system clock by a wide margin.
module i2c_ee_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic ev_start,
    output logic ev_stop
);
    logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_d, sda_d;

    // Purpose: shift the raw lines through the synchroniser and keep the previous sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[SYNC_STAGES-1];
            sda_d    <= sda_pipe[SYNC_STAGES-1];
        end
    end

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    // Purpose: decode edges and bus conditions from two consecutive samples.
    always_comb begin
        scl_rise = scl_s & ~scl_d;
        scl_fall = ~scl_s & scl_d;
        ev_start = scl_s & scl_d & sda_d & ~sda_s;
        ev_stop  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/i2c_ee_mem.sv
// Storage array standing in for the non-volatile cells.
// One synchronous write port, one asynchronous read port. No reset:
// contents survive a reset, as non-volatile cells would.
module i2c_ee_mem #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    // Purpose: store one byte when the controller commits a write.
    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/i2c_ee_ctrl.sv
// Protocol controller of the EEPROM slave.
// Receives the device address, the two pointer bytes and a data byte, commits
// the write on STOP, runs the programming-cycle counter, and streams read
// bytes. Works only on the synchronised events from i2c_ee_sync.
// Assumes ADDR_W >= 9 and PROG_CYCLES >= 1.
module i2c_ee_ctrl
    import i2c_ee_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PROG_CYCLES = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        strap,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic [7:0]        rdata,
    output logic              sda_oe,
    output logic              busy,
    output logic              we,
    output logic [ADDR_W-1:0] ptr,
    output logic [7:0]        wdata
);
    localparam int HI_W  = ADDR_W - 8;
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);

    ee_state_t        state, after;
    logic [2:0]       bitcnt;
    logic             got8;
    logic [7:0]       shreg, tx;
    logic [HI_W-1:0]  hi;
    logic             wr_pend;
    logic [CNT_W-1:0] pcnt;

    // Purpose: the write is committed on the STOP cycle, outside the programming cycle.
    assign we   = (state != ST_PROG) && ev_stop && wr_pend;
    assign busy = (state == ST_PROG);

    // Purpose: protocol sequencing, bit shifting and programming-cycle timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            after   <= ST_IDLE;
            bitcnt  <= '0;
            got8    <= 1'b0;
            shreg   <= '0;
            tx      <= '0;
            hi      <= '0;
            ptr     <= '0;
            wdata   <= '0;
            wr_pend <= 1'b0;
            sda_oe  <= 1'b0;
            pcnt    <= '0;
        end else if (state == ST_PROG) begin
            if (pcnt == CNT_W'(1)) state <= ST_IDLE;
            else                   pcnt  <= pcnt - 1'b1;
        end else if (ev_start) begin
            state   <= ST_DEV;
            bitcnt  <= '0;
            got8    <= 1'b0;
            wr_pend <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (ev_stop) begin
            if (wr_pend) begin
                state <= ST_PROG;
                pcnt  <= CNT_W'(PROG_CYCLES);
                ptr   <= ptr + 1'b1;
            end else begin
                state <= ST_IDLE;
            end
            wr_pend <= 1'b0;
            got8    <= 1'b0;
            sda_oe  <= 1'b0;
        end else begin
            case (state)
                ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == 3'd7) got8 <= 1'b1;
                    end else if (scl_fall && got8) begin
                        got8   <= 1'b0;
                        bitcnt <= '0;
                        case (state)
                            ST_DEV: begin
                                if (shreg[7:1] == {DEV_TYPE, strap}) begin
                                    sda_oe <= 1'b1;
                                    state  <= ST_ACK;
                                    after  <= shreg[0] ? ST_RDAT : ST_AHI;
                                end else begin
                                    state <= ST_HOLD;
                                end
                            end
                            ST_AHI: begin
                                hi     <= shreg[HI_W-1:0];
                                sda_oe <= 1'b1;
                                state  <= ST_ACK;
                                after  <= ST_ALO;
                            end
                            ST_ALO: begin
                                ptr    <= {hi, shreg};
                                sda_oe <= 1'b1;
                                state  <= ST_ACK;
                                after  <= ST_WDAT;
                            end
                            default: begin
                                wdata   <= shreg;
                                wr_pend <= 1'b1;
                                sda_oe  <= 1'b1;
                                state   <= ST_ACK;
                                after   <= ST_HOLD;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        state  <= after;
                        sda_oe <= 1'b0;
                        if (after == ST_RDAT) begin
                            tx     <= rdata;
                            sda_oe <= ~rdata[7];
                            bitcnt <= '0;
                        end
                    end
                end
                ST_RDAT: begin
                    if (scl_rise) begin
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == 3'd7) got8 <= 1'b1;
                    end else if (scl_fall) begin
                        if (got8) begin
                            got8   <= 1'b0;
                            sda_oe <= 1'b0;
                            state  <= ST_RACK;
                        end else begin
                            tx     <= {tx[6:0], 1'b0};
                            sda_oe <= ~tx[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        ptr <= ptr + 1'b1;
                        if (!sda_s) begin
                            state <= ST_ACK;
                            after <= ST_RDAT;
                        end else begin
                            state <= ST_HOLD;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2c_eeprom_slave.sv
// Top of the I2C EEPROM slave: synchroniser, controller and storage array.
// sda_oe_o high means the pad pulls SDA low; the pad and pull-up are outside.
module i2c_eeprom_slave #(
    parameter int ADDR_W      = 11,
    parameter int PROG_CYCLES = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] strap_i,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o
);
    logic              scl_s, sda_s, scl_rise, scl_fall, ev_start, ev_stop;
    logic              busy, mem_we;
    logic [ADDR_W-1:0] ptr;
    logic [7:0]        wdata, rdata;

    i2c_ee_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .ev_start (ev_start),
        .ev_stop  (ev_stop)
    );

    i2c_ee_ctrl #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap    (strap_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .ev_start (ev_start),
        .ev_stop  (ev_stop),
        .rdata    (rdata),
        .sda_oe   (sda_oe_o),
        .busy     (busy),
        .we       (mem_we),
        .ptr      (ptr),
        .wdata    (wdata)
    );

    i2c_ee_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (ptr),
        .wdata (wdata),
        .raddr (ptr),
        .rdata (rdata)
    );
endmodule

// File: rtl/i2c_eeprom_slave_chk.sv
// Property checker for i2c_eeprom_slave, attached by bind.
// Watches the synchronised SCL, the output enable, the busy flag and the
// array write strobe.
module i2c_eeprom_slave_chk #(
    parameter int PROG_CYCLES = 2000
) (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic sda_oe,
    input logic busy,
    input logic we
);
    localparam int CW = $clog2(PROG_CYCLES + 2);

    logic [CW-1:0] busy_len;

    // Purpose: count consecutive busy cycles so the window length can be judged.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_len <= '0;
        else        busy_len <= busy ? busy_len + 1'b1 : '0;
    end

    // R2: the data line only moves while the clock is low
    p_oe_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);

    // R5: nothing is driven during the programming cycle
    p_busy_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);

    // R4: every committed write opens a programming cycle
    p_commit_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> busy);

    // R5: the programming cycle lasts exactly PROG_CYCLES clocks
    p_prog_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == CW'(PROG_CYCLES)));
endmodule

bind i2c_eeprom_slave i2c_eeprom_slave_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_s  (scl_s),
    .sda_oe (sda_oe_o),
    .busy   (busy),
    .we     (mem_we)
);

// File: tb/i2c_eeprom_slave_bench.sv
// Scoreboard bench: bus tasks queue the expected item, then the observed one;
// a monitor process pairs and compares them.
module i2c_eeprom_slave_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 11;
    localparam int PROG       = 2000;
    localparam int Q          = 10;   // quarter of an SCL period, in clocks

    typedef struct {
        string      tag;
        string      what;
        logic [7:0] val;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'b101;
    logic       sda_oe;
    wire        sda_line = sda_m & ~sda_oe;

    item_t      exp_q[$];
    logic [7:0] obs_q[$];
    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    localparam logic [7:0] DEV_W = 8'hAA;  // 1010 101 0
    localparam logic [7:0] DEV_R = 8'hAB;  // 1010 101 1
    localparam logic [7:0] DEV_X = 8'hA8;  // strap 100: no match

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_eeprom_slave #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG)) u_i2c_eeprom_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap_i  (strap),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic expect_item(input string tag, input string what, input logic [7:0] val);
        item_t it;
        it.tag = tag; it.what = what; it.val = val;
        exp_q.push_back(it);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    // Sends one byte and queues the expected and observed acknowledge (1 = acked).
    task automatic wr_byte(input logic [7:0] b, input bit exp_ack, input string tag);
        logic got;
        expect_item(tag, "ack", {7'd0, exp_ack});
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2*Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        got = ~sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
        obs_q.push_back({7'd0, got});
    endtask

    // Clocks one byte in and answers with master_ack; queues expected and observed data.
    task automatic rd_byte(input logic [7:0] exp_val, input bit master_ack, input string tag);
        logic [7:0] got;
        expect_item(tag, "read data", exp_val);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            got[i] = sda_line; tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = ~master_ack; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
        obs_q.push_back(got);
    endtask

    task automatic write_one(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] d, input string tag);
        bus_start();
        wr_byte(DEV_W, 1'b1, "R1");
        wr_byte(hi, 1'b1, "R2");
        wr_byte(lo, 1'b1, "R2");
        wr_byte(d, 1'b1, tag);
        bus_stop();
    endtask

    // Monitor: pairs every observed result with the oldest expected item.
    initial begin
        forever begin
            @(negedge clk);
            while (obs_q.size() > 0) begin
                logic [7:0] o;
                o = obs_q.pop_front();
                if (exp_q.size() == 0) begin
                    n_run++; n_fail++;
                    $display("FAIL scoreboard: actual %h expected nothing", o);
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    check(e.tag, e.what, o, e.val);
                end
            end
        end
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        tick(190000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R10: released SDA during and after reset
        tick(5);
        check("R10", "oe in reset", {7'd0, sda_oe}, 8'h00);
        rst_n = 1'b1; tick(5);
        check("R10", "oe after reset", {7'd0, sda_oe}, 8'h00);

        // R4: byte write of 0x5C at 0x014, then R5: own address refused while programming
        write_one(8'h00, 8'h14, 8'h5C, "R2");
        bus_start();
        wr_byte(DEV_W, 1'b0, "R5");
        bus_stop();
        tick(PROG + 100);

        // R3: upper bits 11111 of the first byte ignored, write 0x3B at 0x013
        write_one(8'hF8, 8'h13, 8'h3B, "R3");
        tick(PROG + 100);

        // R4: pointer now 0x014, current read returns 0x5C
        bus_start();
        wr_byte(DEV_R, 1'b1, "R6");
        rd_byte(8'h5C, 1'b0, "R4");
        bus_stop();

        // R1: wrong strap bits are not acknowledged
        bus_start();
        wr_byte(DEV_X, 1'b0, "R1");
        bus_stop();

        // top and bottom addresses
        write_one(8'h07, 8'hFF, 8'hC7, "R2");
        tick(PROG + 100);
        write_one(8'h00, 8'h00, 8'hD2, "R2");
        tick(PROG + 100);

        // R9: random read of 0x7FF via repeated START, R6 streaming, R8 wrap, R7 idle after decline
        bus_start();
        wr_byte(DEV_W, 1'b1, "R1");
        wr_byte(8'h07, 1'b1, "R2");
        wr_byte(8'hFF, 1'b1, "R2");
        bus_start();
        wr_byte(DEV_R, 1'b1, "R9");
        rd_byte(8'hC7, 1'b1, "R6");
        rd_byte(8'hD2, 1'b0, "R8");
        rd_byte(8'hFF, 1'b1, "R7");
        bus_stop();

        // R4: a repeated START after the data byte discards the write, no busy window
        bus_start();
        wr_byte(DEV_W, 1'b1, "R1");
        wr_byte(8'h00, 1'b1, "R2");
        wr_byte(8'h13, 1'b1, "R2");
        wr_byte(8'hEE, 1'b1, "R2");
        bus_start();
        wr_byte(DEV_R, 1'b1, "R4");
        rd_byte(8'h3B, 1'b0, "R4");
        bus_stop();

        // R4: a STOP after the pointer bytes writes nothing, slave answers at once
        bus_start();
        wr_byte(DEV_W, 1'b1, "R1");
        wr_byte(8'h00, 1'b1, "R2");
        wr_byte(8'h14, 1'b1, "R2");
        bus_stop();
        bus_start();
        wr_byte(DEV_R, 1'b1, "R5");
        rd_byte(8'h5C, 1'b0, "R4");
        bus_stop();

        // R10: reset returns the pointer to 0, memory keeps 0xD2 there
        rst_n = 1'b0; tick(5);
        check("R10", "oe in second reset", {7'd0, sda_oe}, 8'h00);
        rst_n = 1'b1; tick(5);
        bus_start();
        wr_byte(DEV_R, 1'b1, "R10");
        rd_byte(8'hD2, 1'b0, "R10");
        bus_stop();

        tick(20);
        if (exp_q.size() != 0) begin
            n_run++; n_fail++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule